// File: doc/BRIEF.md
# Nonvolatile Programming Cycle Sequencer

This block times the erase and program phases that follow an accepted write transfer into a small nonvolatile array. A one-cycle start request hands it the number of latched bytes (1 to 8), a page flag and a clock-source select. It first erases the affected bytes, then programs the latched bytes one at a time. While it works, it strobes per-byte erase and program enables towards the array and holds a busy flag for the whole cycle.

Slot length comes from one of two sources. The first is an internal timebase tick, a pulse that arrives once per divided oscillator period; a slot lasts `SLOT_TICKS` of these ticks. The second is an external clock pin, where each slot lasts `EXT_SLOT` rising edges and a single lead-in edge comes before the first slot. With the default of 128 edges per slot, a cycle of n bytes in byte mode takes n×256+1 external periods and a full page takes 1153.

In byte mode each byte gets its own erase slot and then its own program slot. In page mode one erase slot clears all latched bytes together, and the program slots follow, so a full page takes nine slots.

Top module: `nvm_prog_sequencer`

## Requirements
- R1: During and just after reset, `busy` is low and `erase_en` and `prog_en` are all zero.
- R2: While idle, a `start` pulse whose `byte_cnt` is 1 to `NBYTES` makes `busy` high on the next clock. A `start` pulse with a count of 0 or above `NBYTES` is ignored and `busy` stays low.
- R3: In byte mode (`page_mode`=0) with n bytes, slots 0 to n-1 drive `erase_en` one-hot at bit 0, then bit 1, up to bit n-1. Slots n to 2n-1 then drive `prog_en` one-hot in the same bit order.
- R4: In page mode (`page_mode`=1) with n bytes, slot 0 drives `erase_en` bits 0 to n-1 together. Slots 1 to n then drive `prog_en` one-hot at bits 0 to n-1 in turn.
- R5: With `ext_sel`=0, each slot lasts exactly `SLOT_TICKS` cycles in which `tick` is high, and `ext_clk` has no effect.
- R6: With `ext_sel`=1, the first rising edge of `ext_clk` is a lead-in with no enables active, and each slot then lasts `EXT_SLOT` rising edges. `tick` has no effect in this mode.
- R7: `busy` falls on the clock edge that takes the final event of the last program slot, so it is low one clock after that event is presented.
- R8: While busy, a further `start` is ignored. Changes on `byte_cnt`, `page_mode` or `ext_sel` after the cycle has started have no effect on it.
- R9: `erase_en` and `prog_en` are never active at the same time, and both are zero whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a programming cycle |
| byte_cnt | input | $clog2(NBYTES+1) | Number of latched bytes, captured at start |
| page_mode | input | 1 | 1 selects page mode, captured at start |
| tick | input | 1 | Internal timebase pulse, one cycle wide |
| ext_clk | input | 1 | External timing clock, sampled on clk |
| ext_sel | input | 1 | 1 times slots from ext_clk, captured at start |
| busy | output | 1 | High for the whole programming cycle |
| erase_en | output | NBYTES | Per-byte erase strobes |
| prog_en | output | NBYTES | Per-byte program strobes |

## Verification
A timing event is either a `tick` high or an `ext_clk` level that was low on the previous clock and is high now. An event presented before a rising edge shows on `busy` and the enables after that edge, and `busy` rises on the clock right after `start`. The bench drives every input at the falling edge and samples every output at the next falling edge. It counts the events that have already passed a rising edge and, from that count alone, computes the slot and therefore the enables that are due. It also checks that `busy` drops at the sample that follows the final event, with no slack in either direction.

// File: rtl/nvm_prog_sequencer.sv
module nvm_prog_sequencer #(
  parameter int NBYTES     = 8,
  parameter int SLOT_TICKS = 16,
  parameter int EXT_SLOT   = 128,
  localparam int CW = $clog2(NBYTES + 1),
  localparam int IW = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int SLOT_MAX = (SLOT_TICKS > EXT_SLOT) ? SLOT_TICKS : EXT_SLOT,
  localparam int UW = (SLOT_MAX > 1) ? $clog2(SLOT_MAX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CW-1:0]     byte_cnt,
  input  logic              page_mode,
  input  logic              tick,
  input  logic              ext_clk,
  input  logic              ext_sel,
  output logic              busy,
  output logic [NBYTES-1:0] erase_en,
  output logic [NBYTES-1:0] prog_en
);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_ERASE, S_PROG} state_t;

  state_t          st;
  logic [CW-1:0]   cnt_q;
  logic            page_q;
  logic            ext_q;
  logic            ext_d;
  logic [IW-1:0]   idx;
  logic [UW-1:0]   unit;
  logic [NBYTES-1:0] mask;

  wire cnt_ok    = (byte_cnt != '0) && (byte_cnt <= CW'(NBYTES));
  wire ev        = ext_q ? (ext_clk & ~ext_d) : tick;
  wire [UW-1:0] slot_last = ext_q ? UW'(EXT_SLOT - 1) : UW'(SLOT_TICKS - 1);
  wire slot_end  = ev && (unit == slot_last);
  wire last_byte = (CW'(idx) + CW'(1)) == cnt_q;
  wire [NBYTES-1:0] one_hot = NBYTES'(1) << idx;

  for (genvar i = 0; i < NBYTES; i++) begin : g_mask
    assign mask[i] = CW'(i) < cnt_q;
  end

  assign busy     = (st != S_IDLE);
  assign erase_en = (st == S_ERASE) ? (page_q ? mask : one_hot) : '0;
  assign prog_en  = (st == S_PROG) ? one_hot : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt_q  <= '0;
      page_q <= 1'b0;
      ext_q  <= 1'b0;
      ext_d  <= 1'b0;
      idx    <= '0;
      unit   <= '0;
    end else begin
      ext_d <= ext_clk;
      case (st)
        S_IDLE: if (start && cnt_ok) begin
          cnt_q  <= byte_cnt;
          page_q <= page_mode;
          ext_q  <= ext_sel;
          idx    <= '0;
          unit   <= '0;
          st     <= ext_sel ? S_LEAD : S_ERASE;
        end
        S_LEAD: if (ev) st <= S_ERASE;
        S_ERASE, S_PROG: begin
          if (ev) unit <= slot_end ? '0 : unit + 1'b1;
          if (slot_end) begin
            if (st == S_ERASE) begin
              if (page_q || last_byte) begin
                st  <= S_PROG;
                idx <= '0;
              end else begin
                idx <= idx + 1'b1;
              end
            end else begin
              if (last_byte) st <= S_IDLE;
              else idx <= idx + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nvm_prog_sequencer_chk.sv
module nvm_prog_sequencer_chk #(
  parameter int NBYTES = 8,
  parameter int CW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CW-1:0]     byte_cnt,
  input logic              busy,
  input logic [NBYTES-1:0] erase_en,
  input logic [NBYTES-1:0] prog_en
);

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && byte_cnt != '0 && byte_cnt <= CW'(NBYTES)) |=> busy); // R2
  AST_BAD_COUNT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (byte_cnt == '0 || byte_cnt > CW'(NBYTES))) |=> !busy); // R2
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !((|erase_en) && (|prog_en))); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (erase_en == '0 && prog_en == '0)); // R9
  AST_PROG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(prog_en)); // R3
  AST_PROG_AFTER_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|prog_en) |-> $past(|erase_en)); // R3
  AST_END_AFTER_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(|prog_en)); // R7

endmodule

bind nvm_prog_sequencer nvm_prog_sequencer_chk #(.NBYTES(NBYTES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .byte_cnt(byte_cnt),
  .busy(busy), .erase_en(erase_en), .prog_en(prog_en)
);

// File: tb/nvm_prog_sequencer_test.sv
module nvm_prog_sequencer_test;
  localparam int NB = 8, ST = 16, ES = 128, IDIV = 3, EDIV = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, page_mode, tick, ext_clk, ext_sel, busy;
  logic [3:0] byte_cnt;
  logic [NB-1:0] erase_en, prog_en;

  nvm_prog_sequencer #(.NBYTES(NB), .SLOT_TICKS(ST), .EXT_SLOT(ES)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_cnt(byte_cnt),
    .page_mode(page_mode), .tick(tick), .ext_clk(ext_clk), .ext_sel(ext_sel),
    .busy(busy), .erase_en(erase_en), .prog_en(prog_en));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [2*NB-1:0] exp_en(input bit page, input bit ext, input int n, input int e);
    int s;
    logic [NB-1:0] m;
    m = NB'((16'(1) << n) - 16'(1));
    if (ext) begin
      if (e < 1) return '0;
      s = (e - 1) / ES;
    end else s = e / ST;
    if (page) return (s == 0) ? {m, NB'(0)} : {NB'(0), NB'(1) << (s - 1)};
    return (s < n) ? {NB'(1) << s, NB'(0)} : {NB'(0), NB'(1) << (s - n)};
  endfunction

  function automatic int total_ev(input bit page, input bit ext, input int n);
    int slots;
    slots = page ? n + 1 : 2 * n;
    return ext ? 1 + slots * ES : slots * ST;
  endfunction

  task automatic run(input bit page, input bit ext, input int n);
    int e, cyc, tot, bad, bad_act, bad_exp, div;
    bit evn, last_ev;
    tot = total_ev(page, ext, n);
    div = ext ? EDIV : IDIV;
    e = 0; cyc = 0; bad = 0; bad_act = 0; bad_exp = 0; last_ev = 0;
    @(negedge clk);
    page_mode = page; ext_sel = ext; byte_cnt = 4'(n); start = 1'b1; tick = 1'b0; ext_clk = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    while (busy && cyc < 20000) begin
      evn = (cyc % div) == div - 1;
      if (ext) begin ext_clk = evn; tick = !evn; end
      else begin tick = evn; ext_clk = (cyc % 3) == 1; end
      if (cyc == 5) begin
        start = 1'b1; byte_cnt = (n == 1) ? 4'd8 : 4'd1;
        page_mode = !page; ext_sel = !ext;
      end
      if (cyc == 6) start = 1'b0;
      @(negedge clk);
      if (evn) e++;
      last_ev = evn;
      cyc++;
      if (busy && {erase_en, prog_en} !== exp_en(page, ext, n, e) && bad == 0) begin
        bad = 1; bad_act = int'({erase_en, prog_en}); bad_exp = int'(exp_en(page, ext, n, e));
      end
    end
    tick = 1'b0; ext_clk = 1'b0; start = 1'b0;
    chk(bad == 0, page ? "R4" : "R3", "enable pattern", bad_act, bad_exp);
    chk(e == tot, ext ? "R6" : "R5", "events until busy low", e, tot);
    chk(last_ev && !busy, "R7", "busy low right after final event", int'(busy), 0);
    chk(bad == 0 && e == tot, "R8", "restart and input changes ignored", e, tot);
    @(negedge clk);
    chk(erase_en == '0 && prog_en == '0, "R9", "enables when idle", int'({erase_en, prog_en}), 0);
  endtask

  localparam logic [5:0] VEC [8] = '{
    {1'b0, 1'b0, 4'd1}, {1'b0, 1'b0, 4'd3}, {1'b1, 1'b0, 4'd8}, {1'b1, 1'b0, 4'd5},
    {1'b0, 1'b1, 4'd1}, {1'b0, 1'b1, 4'd2}, {1'b1, 1'b1, 4'd8}, {1'b0, 1'b0, 4'd8}};

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; page_mode = 1'b0; tick = 1'b0; ext_clk = 1'b0;
    ext_sel = 1'b0; byte_cnt = 4'd3;
    repeat (2) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && erase_en == '0 && prog_en == '0, "R1", "reset state",
        int'({busy, erase_en, prog_en}), 0);
    start = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "after reset release", int'(busy), 0);

    byte_cnt = 4'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b0, "R2", "count 0 ignored", int'(busy), 0);
    byte_cnt = 4'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b0, "R2", "count 9 ignored", int'(busy), 0);
    @(negedge clk);
    chk(busy == 1'b0, "R2", "still idle", int'(busy), 0);

    for (int v = 0; v < 8; v++) run(VEC[v][5], VEC[v][4], int'(VEC[v][3:0]));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule